// File: doc/BRIEF.md
# Speculative Read Prefetch Queue

This block sits between a stream of compute-side load requests and a single request channel toward a memory-expander endpoint. Every accepted load is queued as a demand read. In parallel, the load's 256-byte block is folded into a queue of speculative read commands. Those commands are issued to the endpoint on the same channel whenever no demand read is waiting, so that the endpoint can stage the data before the demand read arrives. A speculative command names an aligned region of one to four 256-byte blocks. Its length code sits in the two low address bits, which alignment leaves free.

Each issued region is recorded in a small ring buffer. A later load whose block is already recorded adds no new speculation. When a demand read is forwarded and its block lies in a recorded region, it goes out as an ordinary read with a hit flag raised. The endpoint's reported load level steers speculation. A light load grows the region size step by step. A moderate overload halves the speculative issue rate. A severe overload stops speculation entirely. An address window, built from the blocks still pending in both queues, bounds how far beyond them a region may reach.

Top module: `specrd_prefetch`

## Requirements
- R1: After reset, no request is offered, a load is accepted, the ring buffer is empty and the granularity is one block (256 B).
- R2: `ld_ready` is low only when the demand queue holds MQ_DEPTH loads. Every accepted load leaves as exactly one demand read (`rq_spec`=0), in acceptance order, with its full address unchanged.
- R3: While a demand read is waiting it is the one offered, and it stays offered with the same address until `rq_ready` takes it. Speculative commands are offered only when the demand queue is empty.
- R4: A speculative command carries the region's first block number in `rq_addr[AW-1:8]` and zeros in `rq_addr[7:2]`. Its `rq_addr[1:0]` holds the length code: 0, 1, 2 and 3 stand for 1, 2, 3 and 4 blocks (256, 512, 768 and 1024 bytes).
- R5: A load whose block lies in the newest pending region adds nothing. A load whose block is the block just past that region extends the region by one, up to four blocks. The newest region is only a merge target if it is not being issued in the same cycle.
- R6: Any other tracked load opens a new region that starts at its block and has the current granularity as its length, provided the speculative queue has a free slot. Otherwise it gets no speculation.
- R7: `ep_load` is decoded as follows: 0 = light, 1 = optimal, 2 = moderate overload, 3 = severe overload. At level 0, each speculative issue doubles the granularity (1, 2, 4 blocks, capped at 4). Level 1 and level 2 hold the granularity. Level 3 resets it to one block, offers no speculative command and tracks no new loads.
- R8: At level 2, a cycle in which a speculative command was taken is followed by a cycle in which none is offered.
- R9: The issued length is the pending length clipped so the region ends no later than WIN_AHEAD blocks past the highest block pending in either queue.
- R10: The ring buffer keeps the last RB_DEPTH issued regions and overwrites the oldest when full. A load whose block lies in a recorded region adds no speculative entry.
- R11: `rq_hit` is 1 on a demand read exactly when its block lies in a region recorded before that cycle. It is never 1 on a speculative command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted this cycle when valid |
| ld_addr | input | AW | Load byte address |
| ep_load | input | 2 | Endpoint load level, 0 light to 3 severe |
| rq_valid | output | 1 | Request offered to the endpoint link |
| rq_ready | input | 1 | Link takes the offered request |
| rq_addr | output | AW | Demand byte address, or speculative block base with length code |
| rq_spec | output | 1 | 1 for a speculative command, 0 for a demand read |
| rq_hit | output | 1 | Demand read falls in a recorded speculative region |

## Verification
The bench drives ascending and descending streams of 64-byte loads, so several loads share a block. It also drives block-stride runs that exercise merging up to four blocks and a stride pattern that revisits 24 regions so the 16-entry ring wraps. A design that merged into the region being issued in the same cycle, or that let a region grow past four blocks, would produce a wrong length code. A design with an off-by-one in the window clip would send regions that run too far ahead on descending streams. A ring that failed to drop its oldest entry would raise hits that should not occur and would suppress speculation that should happen. The bench also holds moderate and severe levels while a backlog is pending, which catches speculation that leaks through, a rate limit that does not hold, and granularity that does not fall back to one block.

// File: rtl/sr_pf_pkg.sv
package sr_pf_pkg;
  // Size of one speculative block in address bits.
  localparam int unsigned BLK_SHIFT = 8;
  // Largest region in blocks, bounded by the two-bit length code.
  localparam int unsigned MAX_BLKS  = 4;

  typedef logic [2:0] nblk_t;

  typedef enum logic [1:0] {
    LD_LIGHT  = 2'd0,
    LD_OPT    = 2'd1,
    LD_MOD    = 2'd2,
    LD_SEVERE = 2'd3
  } ep_load_e;

  // True when block number blk lies in [base, base+n).
  function automatic logic region_has(input logic [63:0] base, input nblk_t n,
                                      input logic [63:0] blk);
    return (blk >= base) && (blk < base + 64'(n));
  endfunction

  // Length code carried in the two low address bits of a speculative command.
  function automatic logic [1:0] len_code(input nblk_t n);
    return 2'(n - 3'd1);
  endfunction
endpackage

// File: rtl/sr_demand_q.sv
module sr_demand_q import sr_pf_pkg::*; #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8   // power of two
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [AW-1:0]           push_addr,
  input  logic                    pop,
  output logic                    full,
  output logic                    empty,
  output logic [AW-1:0]           head_addr,
  output logic [AW-BLK_SHIFT-1:0] max_blk
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [AW-1:0]    slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;

  always_comb begin
    vld_d = vld_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (pop) begin
      vld_d[rp_q] = 1'b0;
      rp_d        = rp_q + PW'(1);
    end
    if (push) begin
      vld_d[wp_q] = 1'b1;
      wp_d        = wp_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
    end
  end

  // Payload storage needs no reset: slots are read only while valid.
  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= push_addr;
  end

  assign full      = &vld_q;
  assign empty     = ~|vld_q;
  assign head_addr = slot_q[rp_q];

  always_comb begin
    max_blk = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (vld_q[i] && (slot_q[i][AW-1:BLK_SHIFT] > max_blk))
        max_blk = slot_q[i][AW-1:BLK_SHIFT];
    end
  end
endmodule

// File: rtl/sr_spec_q.sv
module sr_spec_q import sr_pf_pkg::*; #(
  parameter int unsigned BW    = 24,
  parameter int unsigned DEPTH = 4   // power of two
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [BW-1:0] push_base,
  input  nblk_t         push_len,
  input  logic          pop,
  input  logic          ext,
  output logic          full,
  output logic          empty,
  output logic          single,
  output logic [BW-1:0] head_base,
  output nblk_t         head_len,
  output logic [BW-1:0] tail_base,
  output nblk_t         tail_len,
  output logic [BW-1:0] max_base
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [BW-1:0]    base_q [DEPTH];
  nblk_t            len_q  [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d, tp;

  assign tp = wp_q - PW'(1);

  always_comb begin
    vld_d = vld_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (pop) begin
      vld_d[rp_q] = 1'b0;
      rp_d        = rp_q + PW'(1);
    end
    if (push) begin
      vld_d[wp_q] = 1'b1;
      wp_d        = wp_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      base_q[wp_q] <= push_base;
      len_q[wp_q]  <= push_len;
    end
    if (ext) len_q[tp] <= len_q[tp] + 3'd1;
  end

  assign full      = &vld_q;
  assign empty     = ~|vld_q;
  assign single    = ($countones(vld_q) == 1);
  assign head_base = base_q[rp_q];
  assign head_len  = len_q[rp_q];
  assign tail_base = base_q[tp];
  assign tail_len  = len_q[tp];

  always_comb begin
    max_base = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (vld_q[i] && (base_q[i] > max_base)) max_base = base_q[i];
    end
  end
endmodule

// File: rtl/sr_ring.sv
module sr_ring import sr_pf_pkg::*; #(
  parameter int unsigned BW    = 24,
  parameter int unsigned DEPTH = 16  // power of two
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_base,
  input  nblk_t         wr_len,
  input  logic [BW-1:0] qa_blk,
  output logic          qa_hit,
  input  logic [BW-1:0] qb_blk,
  output logic          qb_hit
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [BW-1:0]    base_q [DEPTH];
  nblk_t            len_q  [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PW-1:0]    wp_q, wp_d;
  logic [DEPTH-1:0] ma, mb;

  always_comb begin
    vld_d = vld_q;
    wp_d  = wp_q;
    if (wr_en) begin
      vld_d[wp_q] = 1'b1;
      wp_d        = wp_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wp_q  <= wp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_q[wp_q] <= wr_base;
      len_q[wp_q]  <= wr_len;
    end
  end

  // One comparator pair per entry, all entries searched in the same cycle.
  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
    assign ma[g] = vld_q[g] && region_has(64'(base_q[g]), len_q[g], 64'(qa_blk));
    assign mb[g] = vld_q[g] && region_has(64'(base_q[g]), len_q[g], 64'(qb_blk));
  end

  assign qa_hit = |ma;
  assign qb_hit = |mb;
endmodule

// File: rtl/specrd_prefetch.sv
module specrd_prefetch import sr_pf_pkg::*; #(
  parameter int unsigned AW        = 32,
  parameter int unsigned MQ_DEPTH  = 8,
  parameter int unsigned SQ_DEPTH  = 4,
  parameter int unsigned RB_DEPTH  = 16,
  parameter int unsigned WIN_AHEAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ep_load,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [AW-1:0] rq_addr,
  output logic          rq_spec,
  output logic          rq_hit
);
  localparam int unsigned BW = AW - BLK_SHIFT;
  localparam int unsigned WW = BW + 2;

  ep_load_e      lvl;
  logic [BW-1:0] ld_blk;
  logic          ld_fire, dm_fire, sp_fire, dm_avail, sp_ok;

  logic          mq_full, mq_empty;
  logic [AW-1:0] mq_head;
  logic [BW-1:0] mq_max;

  logic          sq_full, sq_empty, sq_single, sq_push, sq_ext;
  logic [BW-1:0] sq_hbase, sq_tbase, sq_max;
  nblk_t         sq_hlen, sq_tlen;

  logic          rb_hit_ld, rb_hit_dm;

  nblk_t         gran_q, gran_d;
  logic          cool_q, cool_d;

  logic [BW-1:0] top_blk;
  logic [WW-1:0] win_hi, room;
  nblk_t         clip_len;
  logic [AW-1:0] spec_addr;
  logic          track, tail_ok, in_tail, adj;

  assign lvl    = ep_load_e'(ep_load);
  assign ld_blk = ld_addr[AW-1:BLK_SHIFT];

  sr_demand_q #(.AW(AW), .DEPTH(MQ_DEPTH)) u_mq (
    .clk(clk), .rst_n(rst_n),
    .push(ld_fire), .push_addr(ld_addr), .pop(dm_fire),
    .full(mq_full), .empty(mq_empty), .head_addr(mq_head), .max_blk(mq_max)
  );

  sr_spec_q #(.BW(BW), .DEPTH(SQ_DEPTH)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .push(sq_push), .push_base(ld_blk), .push_len(gran_q),
    .pop(sp_fire), .ext(sq_ext),
    .full(sq_full), .empty(sq_empty), .single(sq_single),
    .head_base(sq_hbase), .head_len(sq_hlen),
    .tail_base(sq_tbase), .tail_len(sq_tlen), .max_base(sq_max)
  );

  sr_ring #(.BW(BW), .DEPTH(RB_DEPTH)) u_rb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sp_fire), .wr_base(sq_hbase), .wr_len(clip_len),
    .qa_blk(ld_blk), .qa_hit(rb_hit_ld),
    .qb_blk(mq_head[AW-1:BLK_SHIFT]), .qb_hit(rb_hit_dm)
  );

  // Arbitration: demand reads always win the shared request channel.
  assign dm_avail = !mq_empty;
  assign sp_ok    = !sq_empty && (lvl != LD_SEVERE) && !((lvl == LD_MOD) && cool_q);
  assign rq_valid = dm_avail || sp_ok;
  assign rq_spec  = !dm_avail;
  assign dm_fire  = dm_avail && rq_ready;
  assign sp_fire  = !dm_avail && sp_ok && rq_ready;
  assign ld_ready = !mq_full;
  assign ld_fire  = ld_valid && ld_ready;

  // Window: region may not end beyond the highest pending block plus WIN_AHEAD.
  assign top_blk  = (mq_max > sq_max) ? mq_max : sq_max;
  assign win_hi   = WW'(top_blk) + WW'(WIN_AHEAD);
  assign room     = win_hi - WW'(sq_hbase) + WW'(1);
  assign clip_len = (room < WW'(sq_hlen)) ? nblk_t'(room) : sq_hlen;

  assign spec_addr = {sq_hbase, {(BLK_SHIFT-2){1'b0}}, len_code(clip_len)};
  assign rq_addr   = dm_avail ? mq_head : spec_addr;
  assign rq_hit    = dm_avail && rb_hit_dm;

  // Speculation bookkeeping for an accepted load.
  assign track   = ld_fire && !rb_hit_ld && (lvl != LD_SEVERE);
  assign tail_ok = !sq_empty && !(sq_single && sp_fire);
  assign in_tail = region_has(64'(sq_tbase), sq_tlen, 64'(ld_blk));
  assign adj     = (WW'(ld_blk) == WW'(sq_tbase) + WW'(sq_tlen)) &&
                   (sq_tlen < nblk_t'(MAX_BLKS));
  assign sq_ext  = track && tail_ok && !in_tail && adj;
  assign sq_push = track && !(tail_ok && (in_tail || adj)) && !sq_full;

  always_comb begin
    gran_d = gran_q;
    if (lvl == LD_SEVERE)
      gran_d = 3'd1;
    else if ((lvl == LD_LIGHT) && sp_fire)
      gran_d = (gran_q >= 3'd2) ? nblk_t'(MAX_BLKS) : (gran_q << 1);
    cool_d = sp_fire && (lvl == LD_MOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gran_q <= 3'd1;
      cool_q <= 1'b0;
    end else begin
      gran_q <= gran_d;
      cool_q <= cool_d;
    end
  end
endmodule

// File: rtl/sr_pf_chk.sv
module sr_pf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ep_load,
  input logic       rq_valid,
  input logic       rq_ready,
  input logic       rq_spec,
  input logic       rq_hit,
  input logic [5:0] rq_mid,
  input logic [31:0] rq_addr32
);
  // R3: a waiting demand read is held with the same address
  assert_demand_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_spec && !rq_ready |=> rq_valid && !rq_spec && $stable(rq_addr32));

  // R4: speculative commands keep the bits between block and length code clear
  assert_spec_format_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_spec |-> rq_mid == 6'd0);

  // R7: severe overload offers no speculative command
  assert_severe_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_spec |-> ep_load != 2'd3);

  // R8: at moderate overload speculative issues are never back to back
  assert_rate_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rq_valid && rq_ready && rq_spec && (ep_load == 2'd2)) && (ep_load == 2'd2)
      |-> !(rq_valid && rq_spec));

  // R11: hit flag rides only on demand reads
  assert_hit_demand_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rq_hit |-> rq_valid && !rq_spec);
endmodule

bind specrd_prefetch sr_pf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ep_load(ep_load),
  .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_spec(rq_spec), .rq_hit(rq_hit),
  .rq_mid(rq_addr[7:2]), .rq_addr32(32'(rq_addr))
);

// File: tb/specrd_prefetch_tb.sv
module specrd_prefetch_tb;
  localparam int AW    = 32;
  localparam int MQD   = 8;
  localparam int SQD   = 4;
  localparam int RBD   = 16;
  localparam int AHEAD = 1;

  logic          clk;
  logic          rst_n;
  logic          ld_valid;
  logic          ld_ready;
  logic [AW-1:0] ld_addr;
  logic [1:0]    ep_load;
  logic          rq_valid;
  logic          rq_ready;
  logic [AW-1:0] rq_addr;
  logic          rq_spec;
  logic          rq_hit;

  int checks;
  int fails;
  bit done;

  specrd_prefetch #(.AW(AW), .MQ_DEPTH(MQD), .SQ_DEPTH(SQD),
                    .RB_DEPTH(RBD), .WIN_AHEAD(AHEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ep_load(ep_load), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_spec(rq_spec), .rq_hit(rq_hit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference state
  int m_mq[$];
  int sq_b[$];
  int sq_l[$];
  int rb_b[RBD];
  int rb_l[RBD];
  bit rb_v[RBD];
  int rb_wp;
  int m_gran;
  bit m_cool;
  bit last_acc;
  int k;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_mq.delete(); sq_b.delete(); sq_l.delete();
    for (int i = 0; i < RBD; i++) begin rb_v[i] = 0; rb_b[i] = 0; rb_l[i] = 0; end
    rb_wp = 0; m_gran = 1; m_cool = 0; last_acc = 0;
  endtask

  function automatic bit m_cover(int b);
    for (int i = 0; i < RBD; i++)
      if (rb_v[i] && b >= rb_b[i] && b < rb_b[i] + rb_l[i]) return 1;
    return 0;
  endfunction

  // Compare DUT against the model for this cycle, then advance the model.
  task automatic step();
    int lvl, e_addr, hi, cl, lb, pre_sq, t;
    bit e_ready, dm, spok, e_valid, e_spec, e_hit, dmf, spf, ldf, lcov;
    #1;
    lvl     = int'(ep_load);
    e_ready = m_mq.size() < MQD;
    dm      = m_mq.size() > 0;
    spok    = sq_b.size() > 0 && lvl != 3 && !(lvl == 2 && m_cool);
    e_valid = dm || spok;
    e_spec  = !dm;
    e_hit   = 0;
    e_addr  = 0;
    cl      = 0;
    if (dm) begin
      e_addr = m_mq[0];
      e_hit  = m_cover(m_mq[0] >> 8);
    end else if (spok) begin
      hi = 0;
      foreach (m_mq[i]) if ((m_mq[i] >> 8) > hi) hi = m_mq[i] >> 8;
      foreach (sq_b[i]) if (sq_b[i] > hi) hi = sq_b[i];
      hi = hi + AHEAD;
      cl = sq_l[0];
      if (hi - sq_b[0] + 1 < cl) cl = hi - sq_b[0] + 1;
      e_addr = (sq_b[0] << 8) | (cl - 1);
    end

    chk(ld_ready == e_ready, "R2 ld_ready", ld_ready, e_ready);
    chk(rq_valid == e_valid, "R3 rq_valid", rq_valid, e_valid);
    if (e_valid) begin
      chk(rq_spec == e_spec, "R3 rq_spec", rq_spec, e_spec);
      if (dm) begin
        chk(rq_addr == AW'(e_addr), "R2 demand address", rq_addr, e_addr);
        chk(rq_hit == e_hit, "R11 rq_hit", rq_hit, e_hit);
      end else begin
        // length and base follow R1 R5 R6 R7 R9 R10
        chk(rq_addr == AW'(e_addr), "R5 R6 R7 R9 R10 spec command", rq_addr, e_addr);
        chk(rq_addr[7:2] == 6'd0, "R4 spec format", rq_addr[7:2], 0);
        chk(rq_hit == 1'b0, "R11 hit on spec", rq_hit, 0);
      end
    end
    if (lvl == 3) chk(!(rq_valid && rq_spec), "R7 severe spec", rq_valid && rq_spec, 0);
    if (lvl == 2 && m_cool) chk(!(rq_valid && rq_spec), "R8 back to back", rq_valid && rq_spec, 0);

    dmf  = dm && rq_ready;
    spf  = !dm && spok && rq_ready;
    ldf  = ld_valid && e_ready;
    lb   = int'(ld_addr >> 8);
    lcov = m_cover(lb);

    if (dmf) void'(m_mq.pop_front());
    pre_sq = sq_b.size();
    if (spf) begin
      rb_b[rb_wp] = sq_b[0];
      rb_l[rb_wp] = cl;
      rb_v[rb_wp] = 1;
      rb_wp = (rb_wp + 1) % RBD;
      void'(sq_b.pop_front());
      void'(sq_l.pop_front());
    end
    if (ldf) begin
      m_mq.push_back(int'(ld_addr));
      if (!lcov && lvl != 3) begin
        t = sq_b.size() - 1;
        if (t >= 0 && lb >= sq_b[t] && lb < sq_b[t] + sq_l[t]) begin
          // already covered by the newest region
        end else if (t >= 0 && lb == sq_b[t] + sq_l[t] && sq_l[t] < 4) begin
          sq_l[t] = sq_l[t] + 1;
        end else if (pre_sq < SQD) begin
          sq_b.push_back(lb);
          sq_l.push_back(m_gran);
        end
      end
    end
    if (lvl == 3) m_gran = 1;
    else if (lvl == 0 && spf) m_gran = (m_gran >= 2) ? 4 : m_gran * 2;
    m_cool   = spf && lvl == 2;
    last_acc = ldf;
  endtask

  function automatic int gen_addr(int mode, int kk);
    case (mode)
      0: return 32'h10000 + kk * 64;
      1: return 32'h30000 - kk * 64;
      2: return 32'h40000 + int'($urandom_range(15)) * 256 + int'($urandom_range(3)) * 64;
      3: return 32'h20000 + kk * 256;
      default: return 32'h80000 + (kk % 24) * 2048;
    endcase
  endfunction

  task automatic run(int n, int lvl, int mode, int pld, int prdy);
    k = 0;
    repeat (n) begin
      @(negedge clk);
      ep_load  = 2'(lvl);
      rq_ready = (int'($urandom_range(99)) < prdy);
      if (last_acc) k++;
      if (!(ld_valid && !last_acc)) begin
        ld_valid = (int'($urandom_range(99)) < pld) && mode != 5;
        ld_addr  = AW'(gen_addr(mode, k));
      end
      step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; ld_valid = 1'b0; ld_addr = '0; ep_load = 2'd1; rq_ready = 1'b1;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rq_valid == 1'b0, "R1 idle after reset", rq_valid, 0);
    chk(ld_ready == 1'b1, "R1 ready after reset", ld_ready, 1);

    run(20, 1, 5, 0, 100);
    run(300, 1, 0, 60, 100);
    run(300, 0, 0, 60, 70);
    run(300, 0, 3, 50, 100);
    run(300, 2, 0, 70, 60);
    run(300, 2, 3, 80, 100);
    run(300, 3, 1, 60, 100);
    run(300, 1, 1, 50, 80);
    run(400, 1, 4, 40, 100);
    run(300, 0, 4, 60, 90);
    run(400, 0, 2, 60, 50);
    run(200, 0, 2, 30, 30);
    run(100, 1, 5, 0, 100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule